// File: doc/BRIEF.md
# Dual-Plane Page-Write Sequencer

This block is the device-side controller of a small byte-wide nonvolatile store. It sits on a synchronous bus where address and data share the low eight lines. A latch strobe captures the address, which is the upper address lines joined with the low lines. A later write or read strobe then moves a data byte over the same low lines. All strobes count only while chip enable is high.

The first write opens a page. Further writes to that page fill a page buffer, and each one restarts a load-window timer. When the timer runs out without a new write, a programming cycle starts. A counter models its length. At the end of that cycle, every buffered byte is copied into the storage array in the same clock edge.

The most significant address bit splits the array into two planes. While one plane is programming, reads to that plane return a status byte. Bit 6 of that byte inverts on every such read, and all other bits are zero. Reads to the other plane return stored data as usual. Software can poll the busy plane until bit 6 stops changing.

Top module: `npw_page_writer`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0 and every array byte reads back as 0x00.
- R2: A cycle with `ce` and `ale` high latches address {`addr_hi`,`ad_in`}. A later `ce`&`wr` cycle writes `ad_in` as data to that address, and a later `ce`&`rd` cycle reads from it.
- R3: `busy` rises exactly `LOAD_WIN` clock edges after the edge that accepted the last page write. Each accepted write restarts this count.
- R4: `busy` stays high for exactly `PROG_CYC` consecutive cycles.
- R5: Buffered bytes stay out of the array until `busy` falls. Until then, reads of those addresses outside the busy plane return the old array contents.
- R6: While `busy` is high, a read whose address bit `ADDR_W-1` equals the plane being programmed returns a status byte. Bit 6 of that byte is 1 on the first such read of the cycle and inverts on each later one. The other bits are 0. After `busy` falls, the same address returns stored data.
- R7: While `busy` is high, reads to the other plane return stored array data.
- R8: A write strobe while `busy` is high is ignored.
- R9: While a page is loading, a write to an address whose page (address bits above log2(`PAGE_BYTES`)) differs from the open page is ignored, and it does not restart the window.
- R10: A write strobe with `ce` low is ignored.
- R11: Read data appears on `rd_data` with `rd_valid` high in the cycle after the edge that sampled the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable; gates all strobes |
| ale | input | 1 | Address latch strobe |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| ad_in | input | 8 | Shared low address / write data lines |
| addr_hi | input | ADDR_W-8 | Upper address lines |
| rd_data | output | 8 | Read data or status byte |
| rd_valid | output | 1 | One-cycle read data qualifier |
| busy | output | 1 | Programming cycle in progress |

## Verification
A read result is due one edge after the read strobe is sampled. The driver queues each expected byte as it issues the strobe. A monitor pops the queue at the falling edge in which `rd_valid` is high, and the driver also confirms `rd_valid` at that same falling edge. The rise of `busy` is checked by counting falling edges after the accepted write: it is low after `LOAD_WIN-1` edges and high after `LOAD_WIN`. A monitor measures each run of `busy` and compares its length with `PROG_CYC`. Array contents are compared only by reads issued after `busy` has been seen low.

// File: rtl/npw_pkg.sv
package npw_pkg;

    localparam int STAT_BIT = 6;
    localparam int MAX_AW   = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } npw_state_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [MAX_AW-1:0] addr;
        logic [7:0]        data;
    } npw_cmd_t;

    function automatic logic [7:0] status_byte(input logic tog);
        logic [7:0] b;
        b = 8'h00;
        b[STAT_BIT] = tog;
        return b;
    endfunction

endpackage

// File: rtl/npw_bus_front.sv
module npw_bus_front
    import npw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              ale,
    input  logic              wr,
    input  logic              rd,
    input  logic [7:0]        ad_in,
    input  logic [ADDR_W-9:0] addr_hi,
    output npw_cmd_t          cmd
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (ce && ale) begin
            addr_q <= {addr_hi, ad_in};
        end
    end

    always_comb begin
        cmd.wr   = ce && wr && !ale;
        cmd.rd   = ce && rd && !ale;
        cmd.addr = MAX_AW'(addr_q);
        cmd.data = ad_in;
    end

endmodule

// File: rtl/npw_seq.sv
module npw_seq
    import npw_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int PG_W     = 3,
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  npw_cmd_t               cmd,
    output logic                   buf_we,
    output logic                   commit,
    output logic                   prog_start,
    output logic                   busy,
    output logic [ADDR_W-PG_W-1:0] open_page
);

    localparam int WC_W = $clog2(LOAD_WIN + 1);
    localparam int PC_W = $clog2(PROG_CYC + 1);
    localparam logic [WC_W-1:0] WIN_LAST  = WC_W'(LOAD_WIN - 1);
    localparam logic [PC_W-1:0] PROG_LAST = PC_W'(PROG_CYC - 1);

    npw_state_e             state;
    logic [WC_W-1:0]        win_cnt;
    logic [PC_W-1:0]        prog_cnt;
    logic [ADDR_W-PG_W-1:0] cmd_page;
    logic                   same_page;

    always_comb begin
        cmd_page   = cmd.addr[ADDR_W-1:PG_W];
        same_page  = (cmd_page == open_page);
        buf_we     = cmd.wr && ((state == ST_IDLE) ||
                                (state == ST_LOAD && same_page));
        prog_start = (state == ST_LOAD) && !buf_we && (win_cnt == WIN_LAST);
        commit     = (state == ST_PROG) && (prog_cnt == PROG_LAST);
        busy       = (state == ST_PROG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            win_cnt   <= '0;
            prog_cnt  <= '0;
            open_page <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd.wr) begin
                        open_page <= cmd_page;
                        win_cnt   <= '0;
                        state     <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (buf_we) begin
                        win_cnt <= '0;
                    end else if (prog_start) begin
                        prog_cnt <= '0;
                        state    <= ST_PROG;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (commit) begin
                        state <= ST_IDLE;
                    end else begin
                        prog_cnt <= prog_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        win_cnt < WC_W'(LOAD_WIN)); // R3
    AST_PROG_BOUND: assert property (@(posedge clk) disable iff (rst)
        prog_cnt < PC_W'(PROG_CYC)); // R4
    AST_START_ENDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> busy); // R3
    AST_LOAD_PAGE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (buf_we && state == ST_LOAD) |-> (cmd.addr[ADDR_W-1:PG_W] == open_page)); // R9

endmodule

// File: rtl/npw_page_buf.sv
module npw_page_buf
    import npw_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int PG_W       = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [PG_W-1:0]       idx,
    input  logic [7:0]            wdata,
    input  logic                  clr,
    input  logic                  busy,
    output logic [PAGE_BYTES-1:0] vld,
    output logic [7:0]            bytes [PAGE_BYTES]
);

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vld[i]   <= 1'b0;
                bytes[i] <= 8'h00;
            end else if (clr) begin
                vld[i] <= 1'b0;
            end else if (we && idx == PG_W'(i)) begin
                vld[i]   <= 1'b1;
                bytes[i] <= wdata;
            end
        end
    end

    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        we |-> !busy); // R8
    AST_CLEAR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        clr |=> (vld == '0)); // R5

endmodule

// File: rtl/npw_array.sv
module npw_array
    import npw_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 8,
    parameter int PG_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd,
    input  logic [ADDR_W-1:0]      raddr,
    input  logic                   busy,
    input  logic                   prog_start,
    input  logic                   commit,
    input  logic [ADDR_W-PG_W-1:0] page,
    input  logic [PAGE_BYTES-1:0]  vld,
    input  logic [7:0]             bytes [PAGE_BYTES],
    output logic [7:0]             rd_data,
    output logic                   rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic       tog;
    logic       stat_rd;

    assign stat_rd = rd && busy && (raddr[ADDR_W-1] == page[ADDR_W-PG_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] <= 8'h00;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (vld[i]) begin
                    mem[{page, PG_W'(i)}] <= bytes[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog      <= 1'b1;
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd;
            if (stat_rd) begin
                rd_data <= status_byte(tog);
            end else if (rd) begin
                rd_data <= mem[raddr];
            end
            if (prog_start) begin
                tog <= 1'b1;
            end else if (stat_rd) begin
                tog <= ~tog;
            end
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd |=> rd_valid); // R11
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !prog_start) |=> (tog != $past(tog))); // R6
    AST_COMMIT_IN_PROG: assert property (@(posedge clk) disable iff (rst)
        commit |-> busy); // R5
    AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> ((rd_data & ~8'h40) == 8'h00)); // R6

endmodule

// File: rtl/npw_page_writer.sv
module npw_page_writer
    import npw_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 8,
    parameter int LOAD_WIN   = 16,
    parameter int PROG_CYC   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              ale,
    input  logic              wr,
    input  logic              rd,
    input  logic [7:0]        ad_in,
    input  logic [ADDR_W-9:0] addr_hi,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy
);

    localparam int PG_W = $clog2(PAGE_BYTES);

    npw_cmd_t               cmd;
    logic                   buf_we;
    logic                   commit;
    logic                   prog_start;
    logic [ADDR_W-PG_W-1:0] open_page;
    logic [PAGE_BYTES-1:0]  vld;
    logic [7:0]             bytes [PAGE_BYTES];

    npw_bus_front #(.ADDR_W(ADDR_W)) u_front (
        .clk(clk), .rst(rst), .ce(ce), .ale(ale), .wr(wr), .rd(rd),
        .ad_in(ad_in), .addr_hi(addr_hi), .cmd(cmd)
    );

    npw_seq #(
        .ADDR_W(ADDR_W), .PG_W(PG_W),
        .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .cmd(cmd), .buf_we(buf_we), .commit(commit),
        .prog_start(prog_start), .busy(busy), .open_page(open_page)
    );

    npw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W)) u_buf (
        .clk(clk), .rst(rst), .we(buf_we), .idx(cmd.addr[PG_W-1:0]),
        .wdata(cmd.data), .clr(commit), .busy(busy), .vld(vld), .bytes(bytes)
    );

    npw_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W)) u_arr (
        .clk(clk), .rst(rst), .rd(cmd.rd), .raddr(cmd.addr[ADDR_W-1:0]),
        .busy(busy), .prog_start(prog_start), .commit(commit),
        .page(open_page), .vld(vld), .bytes(bytes),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    AST_NO_STROBE_WITHOUT_CE: assert property (@(posedge clk) disable iff (rst)
        !ce |-> !buf_we); // R10

endmodule

// File: tb/sim_npw_page_writer.sv
module sim_npw_page_writer;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int PAGE_BYTES = 8;
    localparam int LOAD_WIN   = 16;
    localparam int PROG_CYC   = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce = 1'b0, ale = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0]        ad_in = 8'h00;
    logic [ADDR_W-9:0] addr_hi = '0;
    logic [7:0]        rd_data;
    logic              rd_valid;
    logic              busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] d;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    npw_page_writer #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
        .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
    ) u0 (
        .clk(clk), .rst(rst), .ce(ce), .ale(ale), .wr(wr), .rd(rd),
        .ad_in(ad_in), .addr_hi(addr_hi),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit en);
        @(negedge clk);
        ce = 1'b1; ale = 1'b1; ad_in = a[7:0]; addr_hi = a[ADDR_W-1:8];
        @(negedge clk);
        ale = 1'b0; wr = 1'b1; ad_in = d; ce = en;
        @(negedge clk);
        wr = 1'b0; ce = 1'b1;
    endtask

    task automatic rd_byte(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        ce = 1'b1; ale = 1'b1; ad_in = a[7:0]; addr_hi = a[ADDR_W-1:8];
        @(negedge clk);
        ale = 1'b0; rd = 1'b1;
        it.d = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        rd = 1'b0;
        check(rd_valid === 1'b1, "R11 rd_valid one cycle after read", int'(rd_valid), 1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected rd_valid", 1, 0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check(rd_data === it.d, it.tag, int'(rd_data), int'(it.d));
            end
        end
    end

    // busy run length monitor
    int run = 0;
    always @(negedge clk) begin
        if (rst) begin
            run = 0;
        end else if (busy) begin
            run++;
        end else if (run > 0) begin
            check(run == PROG_CYC, "R4 busy length", run, PROG_CYC);
            run = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        check(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
        rd_byte(10'h005, 8'h00, "R1 array zero after reset");

        // plane 1 page; window timing
        wr_byte(10'h208, 8'h5A, 1'b1);
        wr_byte(10'h20F, 8'h3C, 1'b1);
        repeat (LOAD_WIN - 1) @(negedge clk);
        check(busy === 1'b0, "R3 busy still low before window end", int'(busy), 0);
        @(negedge clk);
        check(busy === 1'b1, "R3 busy rises at window end", int'(busy), 1);
        wait_idle();
        rd_byte(10'h208, 8'h5A, "R2 page byte stored");
        rd_byte(10'h20F, 8'h3C, "R2 page byte stored");

        // plane 0 page with ignored writes
        wr_byte(10'h040, 8'hA5, 1'b1);
        wr_byte(10'h041, 8'hB6, 1'b1);
        rd_byte(10'h041, 8'h00, "R5 old data during load");
        wr_byte(10'h100, 8'h11, 1'b1);
        wr_byte(10'h044, 8'hEE, 1'b0);
        wr_byte(10'h042, 8'hC7, 1'b1);
        wr_byte(10'h043, 8'hD8, 1'b1);
        @(negedge clk);
        while (!busy) @(negedge clk);
        rd_byte(10'h041, 8'h40, "R6 first status read");
        rd_byte(10'h041, 8'h00, "R6 second status read");
        rd_byte(10'h0F0, 8'h40, "R6 third status read");
        rd_byte(10'h208, 8'h5A, "R7 other plane during prog");
        rd_byte(10'h20F, 8'h3C, "R7 other plane during prog");
        wr_byte(10'h042, 8'h99, 1'b1);
        wait_idle();
        rd_byte(10'h040, 8'hA5, "R5 committed after busy");
        rd_byte(10'h041, 8'hB6, "R6 stored data after busy");
        rd_byte(10'h042, 8'hC7, "R8 write during prog ignored");
        rd_byte(10'h043, 8'hD8, "R2 page byte stored");
        rd_byte(10'h044, 8'h00, "R10 write with ce low ignored");
        rd_byte(10'h100, 8'h00, "R9 other page write ignored");

        // plane 1 busy, plane 0 readable
        wr_byte(10'h300, 8'h77, 1'b1);
        @(negedge clk);
        while (!busy) @(negedge clk);
        rd_byte(10'h040, 8'hA5, "R7 plane 0 during plane 1 prog");
        rd_byte(10'h300, 8'h40, "R6 status restarts at 1");
        wait_idle();
        rd_byte(10'h300, 8'h77, "R2 page byte stored");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule